// File: doc/BRIEF.md
# Asynchronous Static RAM Transfer Controller

This block lets an on-chip host perform single 16-bit reads and writes on an external asynchronous static RAM of 256K words. The host gives a byte address, write data, a two-bit byte mask and a read or write request. The controller holds `hostWait` high while the transfer runs, then returns the read data.

Every transfer runs through three timed phases. In the setup phase, address, chip select and byte enables settle. In the strobe phase, the read or write strobe is active. In the hold phase, address, select and write data stay stable after the strobe is released. The length of each phase is a parameter, and each defaults to one clock.

The data bus is split into an output, an input and an output-enable, so a pad ring outside the block can build the bidirectional pin. Each word holds two bytes. The word address is the byte address without its lowest bit.

Top module: `sram_xfer_ctrl`

## Requirements
- R1: After reset, and whenever no transfer runs, `memCsN`, `memWeN`, `memRdN`, `memUbN` and `memLbN` are 1, `memDataOe` is 0 and `hostWait` is 0.
- R2: `memAddr` equals bits [18:1] of the `hostAddr` captured when the request is accepted. Bit 0 of `hostAddr` has no effect on the location accessed.
- R3: During a transfer, `memUbN` is the inverse of `hostByteMask[1]` and `memLbN` is the inverse of `hostByteMask[0]`. The mask is active high, so a 1 enables the byte lane.
- R4: The first clock after acceptance is a setup phase. In it `memCsN` is 0 and both strobes are 1.
- R5: For a write, `memWeN` is 0 for exactly one clock after setup, and `memRdN` stays 1 throughout.
- R6: For a read, `memRdN` is 0 for exactly one clock after setup, and `memWeN` stays 1 throughout.
- R7: The clock after the strobe is a hold phase. In it both strobes are 1, while `memCsN` stays 0 and `memAddr`, `memDataOut` and the byte enables keep their values.
- R8: `memDataOe` is 1 only during a write, from setup through hold inclusive. It is 0 during reads and when idle.
- R9: Read data on `memDataIn` is sampled at the end of the strobe phase. It appears on `hostRdData` from the hold phase on, and stays there until the next read.
- R10: `hostWait` is 1 from the clock after acceptance through the hold phase. Requests raised while `hostWait` is 1 are ignored.
- R11: If `hostRd` and `hostWr` are both 1 at acceptance, a write is performed and the read is dropped.
- R12: After hold the controller is idle again. A request presented in that first idle clock is accepted, so transfers can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 19 | Host byte address |
| hostWrData | input | 16 | Host write data |
| hostByteMask | input | 2 | Byte lane enables, active high |
| hostRd | input | 1 | Read request |
| hostWr | input | 1 | Write request |
| hostWait | output | 1 | Transfer in progress |
| hostRdData | output | 16 | Last word read |
| memAddr | output | 18 | Memory word address |
| memDataOut | output | 16 | Data to memory |
| memDataIn | input | 16 | Data from memory |
| memDataOe | output | 1 | Drive enable for the data bus |
| memCsN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memRdN | output | 1 | Read strobe (output enable of the memory), active low |
| memUbN | output | 1 | Upper byte enable, active low |
| memLbN | output | 1 | Lower byte enable, active low |

## Verification
The bench builds the block with its default widths and with one clock each for setup, strobe and hold. Every phase boundary therefore falls on a known clock, so every pin can be checked phase by phase, down to the single-cycle strobe width and the hold clock. The full 19-bit byte address lets the bench reach the top word as well as an odd/even address pair that shares a word. The bench's memory model exercises each lane mask: a partial-lane write is followed by a read back of the merged word.

// File: rtl/sram_xfer_pkg.sv
package sram_xfer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture host request this cycle
    logic isWr;     // current transfer is a write
    logic busy;     // setup, strobe or hold
    logic strobe;   // strobe phase
    logic capture;  // last strobe cycle of a read
  } xfer_ctrl_t;

endpackage

// File: rtl/sram_xfer_seq.sv
module sram_xfer_seq
  import sram_xfer_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 1,
  parameter int HOLD_CYC   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostRd,
  input  logic       hostWr,
  output xfer_ctrl_t ctrl,
  output logic       hostWait
);

  localparam int MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  phase_t           phase;
  logic [CNT_W-1:0] phaseCnt;
  logic             wrMode;
  logic             lastCyc;
  logic             request;

  assign request = hostRd | hostWr;
  assign lastCyc = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
      wrMode   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (request) begin
          phase    <= PH_SETUP;
          phaseCnt <= CNT_W'(SETUP_CYC - 1);
          wrMode   <= hostWr;           // write wins a tie
        end
        PH_SETUP: if (lastCyc) begin
          phase    <= PH_STROBE;
          phaseCnt <= CNT_W'(STROBE_CYC - 1);
        end else phaseCnt <= phaseCnt - 1'b1;
        PH_STROBE: if (lastCyc) begin
          phase    <= PH_HOLD;
          phaseCnt <= CNT_W'(HOLD_CYC - 1);
        end else phaseCnt <= phaseCnt - 1'b1;
        PH_HOLD: if (lastCyc) phase <= PH_IDLE;
                 else phaseCnt <= phaseCnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load    = (phase == PH_IDLE) & request;
    ctrl.isWr    = wrMode;
    ctrl.busy    = (phase != PH_IDLE);
    ctrl.strobe  = (phase == PH_STROBE);
    ctrl.capture = (phase == PH_STROBE) & lastCyc & ~wrMode;
  end

  assign hostWait = ctrl.busy;

endmodule

// File: rtl/sram_xfer_dp.sv
module sram_xfer_dp
  import sram_xfer_pkg::*;
#(
  parameter int BYTE_ADDR_W = 19,
  parameter int DATA_W      = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xfer_ctrl_t                  ctrl,
  input  logic [BYTE_ADDR_W-1:0]      hostAddr,
  input  logic [DATA_W-1:0]           hostWrData,
  input  logic [DATA_W/8-1:0]         hostByteMask,
  input  logic [DATA_W-1:0]           memDataIn,
  output logic [DATA_W-1:0]           hostRdData,
  output logic [BYTE_ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  output logic [DATA_W-1:0]           memDataOut,
  output logic                        memDataOe,
  output logic                        memCsN,
  output logic                        memWeN,
  output logic                        memRdN,
  output logic [DATA_W/8-1:0]         memLaneN
);

  localparam int LANES  = DATA_W / 8;
  localparam int SHIFT  = $clog2(LANES);
  localparam int WORD_W = BYTE_ADDR_W - SHIFT;

  logic [WORD_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [LANES-1:0]  maskReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      maskReg <= '0;
      rdReg   <= '0;
    end else begin
      if (ctrl.load) begin
        addrReg <= hostAddr[BYTE_ADDR_W-1:SHIFT];
        dataReg <= hostWrData;
        maskReg <= hostByteMask;
      end
      if (ctrl.capture) rdReg <= memDataIn;
    end
  end

  assign memAddr    = addrReg;
  assign memDataOut = dataReg;
  assign hostRdData = rdReg;
  assign memCsN     = ~ctrl.busy;
  assign memDataOe  = ctrl.busy & ctrl.isWr;
  assign memWeN     = ~(ctrl.strobe & ctrl.isWr);
  assign memRdN     = ~(ctrl.strobe & ~ctrl.isWr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign memLaneN[i] = ~(ctrl.busy & maskReg[i]);
  end

endmodule

// File: rtl/sram_xfer_ctrl.sv
module sram_xfer_ctrl
  import sram_xfer_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 1,
  parameter int HOLD_CYC   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [18:0] hostAddr,
  input  logic [15:0] hostWrData,
  input  logic [1:0]  hostByteMask,
  input  logic        hostRd,
  input  logic        hostWr,
  output logic        hostWait,
  output logic [15:0] hostRdData,
  output logic [17:0] memAddr,
  output logic [15:0] memDataOut,
  input  logic [15:0] memDataIn,
  output logic        memDataOe,
  output logic        memCsN,
  output logic        memWeN,
  output logic        memRdN,
  output logic        memUbN,
  output logic        memLbN
);

  xfer_ctrl_t ctrl;
  logic [1:0] laneN;

  sram_xfer_seq #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .hostRd  (hostRd),
    .hostWr  (hostWr),
    .ctrl    (ctrl),
    .hostWait(hostWait)
  );

  sram_xfer_dp #(
    .BYTE_ADDR_W(19),
    .DATA_W     (16)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .hostAddr    (hostAddr),
    .hostWrData  (hostWrData),
    .hostByteMask(hostByteMask),
    .memDataIn   (memDataIn),
    .hostRdData  (hostRdData),
    .memAddr     (memAddr),
    .memDataOut  (memDataOut),
    .memDataOe   (memDataOe),
    .memCsN      (memCsN),
    .memWeN      (memWeN),
    .memRdN      (memRdN),
    .memLaneN    (laneN)
  );

  assign memUbN = laneN[1];
  assign memLbN = laneN[0];

endmodule

// File: rtl/sram_xfer_ctrl_chk.sv
module sram_xfer_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostWait,
  input logic [17:0] memAddr,
  input logic [15:0] memDataOut,
  input logic        memDataOe,
  input logic        memCsN,
  input logic        memWeN,
  input logic        memRdN,
  input logic        memUbN,
  input logic        memLbN
);

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memRdN));

  p_strobe_inside_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || !memRdN) |-> !memCsN);

  p_setup_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memWeN) || $fell(memRdN)) |-> $past(!memCsN && memWeN && memRdN));

  p_drive_on_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> (!memCsN && memRdN));

  p_hold_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCsN && memDataOe && $stable(memAddr) && $stable(memDataOut)));

  p_hold_after_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdN) |-> (!memCsN && $stable(memAddr)));

  p_busy_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> hostWait);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !hostWait |-> (memCsN && memWeN && memRdN && memUbN && memLbN && !memDataOe));

endmodule

bind sram_xfer_ctrl sram_xfer_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostWait  (hostWait),
  .memAddr   (memAddr),
  .memDataOut(memDataOut),
  .memDataOe (memDataOe),
  .memCsN    (memCsN),
  .memWeN    (memWeN),
  .memRdN    (memRdN),
  .memUbN    (memUbN),
  .memLbN    (memLbN)
);

// File: tb/sram_xfer_ctrl_test.sv
module sram_xfer_ctrl_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [18:0] hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [1:0]  hostByteMask = '0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostWait;
  logic [15:0] hostRdData;
  logic [17:0] memAddr;
  logic [15:0] memDataOut;
  logic [15:0] memDataIn;
  logic        memDataOe, memCsN, memWeN, memRdN, memUbN, memLbN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [15:0] memModel [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_xfer_ctrl uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostByteMask(hostByteMask), .hostRd(hostRd), .hostWr(hostWr),
    .hostWait(hostWait), .hostRdData(hostRdData), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataIn(memDataIn), .memDataOe(memDataOe),
    .memCsN(memCsN), .memWeN(memWeN), .memRdN(memRdN),
    .memUbN(memUbN), .memLbN(memLbN)
  );

  function automatic logic [15:0] fillFor(logic [17:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] peek(logic [17:0] a);
    if (memModel.exists(int'(a))) return memModel[int'(a)];
    return fillFor(a);
  endfunction

  // Memory model: drives the bus while read strobe is active
  always_comb memDataIn = (!memCsN && !memRdN) ? peek(memAddr) : 16'h0BAD;

  always @(negedge clk) begin
    if (rstN && !memCsN && !memWeN) begin
      logic [15:0] cur;
      cur = peek(memAddr);
      if (!memUbN) cur[15:8] = memDataOut[15:8];
      if (!memLbN) cur[7:0]  = memDataOut[7:0];
      memModel[int'(memAddr)] = cur;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkIdle(string tag);
    chk({memCsN, memWeN, memRdN, memUbN, memLbN} == 5'b11111, tag,
        {memCsN, memWeN, memRdN, memUbN, memLbN}, 5'b11111);
    chk(!memDataOe && !hostWait, tag, {memDataOe, hostWait}, 2'b00);
  endtask

  // Starts and ends on a negedge with the controller idle
  task automatic doWrite(logic [18:0] a, logic [15:0] d, logic [1:0] m, bit alsoRd);
    hostAddr = a; hostWrData = d; hostByteMask = m; hostWr = 1'b1; hostRd = alsoRd;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
    // setup
    chk(!memCsN && memWeN && memRdN, "R4 write setup", {memCsN, memWeN, memRdN}, 3'b011);
    chk(memAddr == a[18:1], "R2 write address", memAddr, a[18:1]);
    chk({memUbN, memLbN} == ~m, "R3 write lanes", {memUbN, memLbN}, ~m);
    chk(memDataOe && hostWait, "R8 R10 write setup oe/wait", {memDataOe, hostWait}, 2'b11);
    @(negedge clk);
    // strobe
    chk(!memWeN && memRdN, "R5 R11 write strobe", {memWeN, memRdN}, 2'b01);
    chk(memDataOut == d, "R5 write data", memDataOut, d);
    @(negedge clk);
    // hold
    chk(memWeN && memRdN && !memCsN, "R7 write hold ctl", {memCsN, memWeN, memRdN}, 3'b011);
    chk(memDataOe && memDataOut == d && memAddr == a[18:1] && {memUbN, memLbN} == ~m,
        "R7 write hold data", memDataOut, d);
    chk(hostWait, "R10 wait in hold", hostWait, 1'b1);
    @(negedge clk);
    checkIdle("R12 idle after write");
  endtask

  task automatic doRead(logic [18:0] a, logic [15:0] exp, bit poke);
    hostAddr = a; hostByteMask = 2'b11; hostRd = 1'b1; hostWr = 1'b0;
    @(negedge clk);
    hostRd = 1'b0;
    hostWr = poke;       // ignored while busy (R10)
    hostAddr = 19'h0;
    chk(!memCsN && memWeN && memRdN && !memDataOe, "R4 R8 read setup",
        {memCsN, memWeN, memRdN, memDataOe}, 4'b0110);
    chk(memAddr == a[18:1], "R2 read address", memAddr, a[18:1]);
    @(negedge clk);
    chk(!memRdN && memWeN && !memDataOe, "R6 read strobe", {memRdN, memWeN, memDataOe}, 3'b010);
    @(negedge clk);
    hostWr = 1'b0;
    chk(memRdN && !memCsN && hostWait, "R7 read hold", {memCsN, memRdN, hostWait}, 3'b011);
    chk(hostRdData == exp, "R9 read data", hostRdData, exp);
    @(negedge clk);
    checkIdle("R12 idle after read");
    chk(hostRdData == exp, "R9 read data held", hostRdData, exp);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    // R2: odd and even byte address share a word
    doWrite(19'h12345, 16'hA5C3, 2'b11, 1'b0);
    doRead(19'h12344, 16'hA5C3, 1'b0);

    // R3: lane merging
    doWrite(19'h00200, 16'hAAAA, 2'b11, 1'b0);
    doWrite(19'h00200, 16'h5511, 2'b01, 1'b0);
    doRead(19'h00201, 16'hAA11, 1'b0);
    doWrite(19'h00200, 16'h77EE, 2'b10, 1'b0);
    doRead(19'h00200, 16'h7711, 1'b0);

    // top word and unwritten location
    doWrite(19'h7FFFF, 16'hBEEF, 2'b11, 1'b0);
    doRead(19'h7FFFE, 16'hBEEF, 1'b0);
    doRead(19'h04000, fillFor(18'h02000), 1'b0);

    // R11: write wins over simultaneous read
    doWrite(19'h00300, 16'h1234, 2'b11, 1'b1);
    doRead(19'h00300, 16'h1234, 1'b0);

    // R10: write raised while busy with a read is ignored
    doRead(19'h00300, 16'h1234, 1'b1);
    @(negedge clk);
    checkIdle("R10 busy request dropped");
    doRead(19'h00000, fillFor(18'h0), 1'b0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule